// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This block lives on the processor side of a shared, multiplexed address/data and command bus. It decides when the bus may be lent to an external agent and when the processor owns it again. The agent asks for the bus by pulling an active-low request line low. Once the processor has no transfer of its own in flight, the block grants the bus with a single-cycle active-low release pulse. From that same cycle it drops every processor output enable: the address/data group, the command group and their two parity/check groups.

While the agent owns the bus the block stays in a slave state and ignores further requests. The agent signals that it has floated the bus with a one-cycle done pulse. The block then spends a fixed turnaround window with its drivers still off, and only after that turns its enables back on and allows processor requests again. A request that is still held during the turnaround is granted again, but only after the block has spent at least one cycle back in the master state.

Every output is registered. Reset is synchronous and active high. The enables model tri-state control, so no bus is actually driven here.

Top module: `bus_handover_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `release_n` is 1, all `GRP_N` bits of `bus_oe` are 1 and `cpu_req_ok` is 1. This holds even if reset arrives while the agent owns the bus.
- R2: In the master state, if a clock edge samples `ext_req_n`=0 and `cpu_busy`=0, then `release_n` is 0 for exactly the next cycle and returns to 1 in the cycle after it.
- R3: Whenever an edge samples `cpu_busy`=1, `release_n` is 1 in the following cycle, so no grant is issued while the processor is busy.
- R4: `bus_oe` is 4'b0000 in the release cycle. Its bits (bit 0 address/data, bit 1 command, bit 2 data check, bit 3 command parity) are always all equal.
- R5: After the release cycle the block holds `bus_oe`=0, `cpu_req_ok`=0 and `release_n`=1 until an edge samples `agent_done`=1, whatever `ext_req_n` does.
- R6: If `agent_done`=1 is sampled in the slave state, the next `TURN_CYC` cycles are turnaround cycles with `bus_oe`=0 and `cpu_req_ok`=0. The cycle after them is master, with `bus_oe` all ones and `cpu_req_ok`=1.
- R7: A request held low through the turnaround is not granted in the first master cycle. `release_n` goes to 0 one cycle later.
- R8: `cpu_req_ok` is 1 exactly when the block is in master, which is exactly when `bus_oe` is all ones.
- R9: `agent_done` is ignored in the master and release states: it neither changes the outputs nor shortens the slave period.
- R10: The agent may raise `agent_drive` from the second cycle after the release cycle onward, and doing so leaves the slave outputs unchanged. A rise earlier than that, or `agent_drive` high while in master, is a protocol violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_n | input | 1 | External agent bus request, active low |
| cpu_busy | input | 1 | Processor transfer in progress; holds off the grant |
| agent_drive | input | 1 | Agent is driving the bus (monitored for protocol checks) |
| agent_done | input | 1 | One-cycle pulse: agent has floated the bus |
| release_n | output | 1 | Active-low one-cycle bus grant |
| bus_oe | output | GRP_N | Processor output enables, one per bus group |
| cpu_req_ok | output | 1 | Processor may start its own requests |

## Verification
The bench sweeps busy hold-off lengths, slave durations and a held re-request. It checks the exact cycle of every edge. A design with a two-cycle release pulse, or one that grants while busy, would show `release_n` low in a cycle where the bench expects it high. A done pulse is also fired during the release cycle and while idle: a design that accepts it there would return the enables one or two cycles early. The re-request case catches a design that grants straight out of turnaround, or in the first master cycle. A reset is also applied in the middle of slave ownership, and the bench checks that the block comes back up as master.

// File: rtl/hof_pkg.sv
package hof_pkg;

  typedef enum logic [1:0] {
    ST_MASTER = 2'd0,
    ST_GRANT  = 2'd1,
    ST_SLAVE  = 2'd2,
    ST_TURN   = 2'd3
  } hof_state_e;

endpackage

// File: rtl/hof_fsm.sv
module hof_fsm
  import hof_pkg::*;
#(
  parameter int TURN_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_req_n,
  input  logic       cpu_busy,
  input  logic       agent_done,
  output hof_state_e state_q,
  output hof_state_e state_d
);

  localparam int TCNT_W = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
  localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(TURN_CYC - 1);

  logic [TCNT_W-1:0] tcnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_MASTER: if (!ext_req_n && !cpu_busy) state_d = ST_GRANT;
      ST_GRANT:  state_d = ST_SLAVE;
      ST_SLAVE:  if (agent_done) state_d = ST_TURN;
      ST_TURN:   if (tcnt_q == TCNT_LAST) state_d = ST_MASTER;
      default:   state_d = ST_MASTER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_MASTER;
    end else begin
      state_q <= state_d;
    end
  end

  // turnaround window counter, cleared outside the turnaround state
  always_ff @(posedge clk) begin
    if (rst || state_q != ST_TURN) begin
      tcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  // R5: slave is held until the agent reports done
  p_slave_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLAVE && !agent_done) |=> (state_q == ST_SLAVE));

  // R6: done in slave moves to turnaround
  p_done_turn_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLAVE && agent_done) |=> (state_q == ST_TURN));

  // R2: release state lasts a single cycle
  p_grant_once_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GRANT) |=> (state_q == ST_SLAVE));

endmodule

// File: rtl/hof_gap_mon.sv
module hof_gap_mon
  import hof_pkg::*;
#(
  parameter int REL_GAP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  hof_state_e state_d,
  input  logic       agent_drive
);

  localparam int GW = $clog2(REL_GAP + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(REL_GAP);

  // cycles elapsed since the release cycle (0 in that cycle), saturating
  logic [GW-1:0] gcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt_q <= GAP_MAX;
    end else if (state_d == ST_GRANT) begin
      gcnt_q <= '0;
    end else if (gcnt_q < GAP_MAX) begin
      gcnt_q <= gcnt_q + 1'b1;
    end
  end

  // R10: the agent may not start driving before the handover gap has elapsed
  p_agent_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(agent_drive) |-> (gcnt_q >= GAP_MAX));

endmodule

// File: rtl/hof_out_regs.sv
module hof_out_regs
  import hof_pkg::*;
#(
  parameter int GRP_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  hof_state_e       state_d,
  output logic             release_n,
  output logic [GRP_N-1:0] bus_oe,
  output logic             cpu_req_ok
);

  always_ff @(posedge clk) begin
    if (rst) begin
      release_n  <= 1'b1;
      cpu_req_ok <= 1'b1;
    end else begin
      release_n  <= (state_d != ST_GRANT);
      cpu_req_ok <= (state_d == ST_MASTER);
    end
  end

  // one registered enable per bus group
  for (genvar g = 0; g < GRP_N; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) begin
        bus_oe[g] <= 1'b1;
      end else begin
        bus_oe[g] <= (state_d == ST_MASTER);
      end
    end
  end

  // R2: release pulse is a single cycle wide
  p_pulse_one_r2: assert property (@(posedge clk) disable iff (rst)
    !release_n |=> release_n);

  // R4: all groups switch together
  p_oe_same_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_oe == '0) || (bus_oe == '1));

endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
  import hof_pkg::*;
#(
  parameter int GRP_N    = 4,
  parameter int REL_GAP  = 2,
  parameter int TURN_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_req_n,
  input  logic             cpu_busy,
  input  logic             agent_drive,
  input  logic             agent_done,
  output logic             release_n,
  output logic [GRP_N-1:0] bus_oe,
  output logic             cpu_req_ok
);

  hof_state_e state_q;
  hof_state_e state_d;

  hof_fsm #(.TURN_CYC(TURN_CYC)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .ext_req_n  (ext_req_n),
    .cpu_busy   (cpu_busy),
    .agent_done (agent_done),
    .state_q    (state_q),
    .state_d    (state_d)
  );

  hof_gap_mon #(.REL_GAP(REL_GAP)) gap_i (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .agent_drive (agent_drive)
  );

  hof_out_regs #(.GRP_N(GRP_N)) out_i (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .release_n  (release_n),
    .bus_oe     (bus_oe),
    .cpu_req_ok (cpu_req_ok)
  );

  // R3: busy sampled at an edge blocks a grant in the next cycle
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_busy |=> release_n);

  // R2: a grant follows a request seen while idle
  p_grant_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(release_n) |-> $past(!ext_req_n && !cpu_busy));

  // R4: drivers off in the release cycle
  p_oe_off_r4: assert property (@(posedge clk) disable iff (rst)
    !release_n |-> (bus_oe == '0));

  // R8: request permission tracks the enables
  p_ok_match_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_req_ok == (bus_oe == '1));

  // R7: no grant in the first master cycle
  p_no_fast_regrant_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_req_ok) |-> release_n);

  // R10: no contention with processor drivers
  p_no_contend_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_req_ok |-> !agent_drive);

endmodule

// File: tb/bus_handover_ctrl_tb_top.sv
module bus_handover_ctrl_tb_top;

  localparam int GRP_N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req_n = 1'b1;
  logic cpu_busy = 1'b0;
  logic agent_drive = 1'b0;
  logic agent_done = 1'b0;
  logic release_n;
  logic [GRP_N-1:0] bus_oe;
  logic cpu_req_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_handover_ctrl #(.GRP_N(GRP_N), .REL_GAP(2), .TURN_CYC(1)) dut_i (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .cpu_busy(cpu_busy),
    .agent_drive(agent_drive), .agent_done(agent_done),
    .release_n(release_n), .bus_oe(bus_oe), .cpu_req_ok(cpu_req_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // pack the outputs: {release_n, cpu_req_ok, bus_oe}
  function automatic logic [31:0] outs();
    return {26'd0, release_n, cpu_req_ok, bus_oe};
  endfunction

  localparam logic [31:0] O_MASTER = {26'd0, 1'b1, 1'b1, 4'hF};
  localparam logic [31:0] O_GRANT  = {26'd0, 1'b0, 1'b0, 4'h0};
  localparam logic [31:0] O_SLAVE  = {26'd0, 1'b1, 1'b0, 4'h0};

  task automatic handover(input int busy_cyc, input int slave_len, input bit rereq);
    // in master, inputs idle, at a negedge
    ext_req_n = 1'b0;
    cpu_busy  = (busy_cyc > 0);
    for (int i = 0; i < busy_cyc; i++) begin
      @(negedge clk);
      check("R3 busy hold", outs(), O_MASTER);
      if (i == busy_cyc - 1) cpu_busy = 1'b0;
    end
    @(negedge clk);
    check("R2/R4 release cycle", outs(), O_GRANT);
    agent_done = 1'b1;                 // R9: done in release state must be ignored
    @(negedge clk);
    agent_done = 1'b0;
    check("R2 pulse ended", outs(), O_SLAVE);
    @(negedge clk);
    check("R9 done ignored in release", outs(), O_SLAVE);
    agent_drive = 1'b1;                // second cycle after release
    ext_req_n   = rereq ? 1'b0 : 1'b1;
    for (int i = 0; i < slave_len; i++) begin
      @(negedge clk);
      check("R5/R10 slave hold", outs(), O_SLAVE);
    end
    agent_drive = 1'b0;
    agent_done  = 1'b1;
    @(negedge clk);
    agent_done = 1'b0;
    check("R6 turnaround", outs(), O_SLAVE);
    @(negedge clk);
    check("R6/R8 back to master", outs(), O_MASTER);
    if (rereq) begin
      @(negedge clk);
      check("R7 regrant", outs(), O_GRANT);
      ext_req_n = 1'b1;
      @(negedge clk);
      check("R7 slave again", outs(), O_SLAVE);
      agent_done = 1'b1;
      @(negedge clk);
      agent_done = 1'b0;
      @(negedge clk);
      check("R6 master after regrant", outs(), O_MASTER);
    end
    @(negedge clk);
    check("R8 idle master", outs(), O_MASTER);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", outs(), O_MASTER);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", outs(), O_MASTER);

    // R9: done while idle has no effect
    agent_done = 1'b1;
    @(negedge clk);
    agent_done = 1'b0;
    check("R9 done in master", outs(), O_MASTER);
    @(negedge clk);
    check("R9 still master", outs(), O_MASTER);

    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 5; s++)
        for (int r = 0; r < 2; r++)
          handover(b, s, r[0]);

    // R1: reset while the agent owns the bus
    ext_req_n = 1'b0;
    @(negedge clk);
    check("R2 grant before reset", outs(), O_GRANT);
    ext_req_n = 1'b1;
    @(negedge clk);
    check("R5 slave before reset", outs(), O_SLAVE);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset from slave", outs(), O_MASTER);
    rst = 1'b0;
    @(negedge clk);
    check("R1 master after reset", outs(), O_MASTER);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule